// File: doc/BRIEF.md
# PLL Shutdown Sequencer

This block decides when a system PLL may be switched off. Software clears an enable bit. The block then asks the bus arbiter for the bus. It counts rising edges of a slow 32 kHz reference that arrives asynchronously, and it waits for a minimum number of fast bus-clock cycles. It also waits for the bus cycle in progress to finish. Only when all of these have happened does it drop the PLL enable output.

A 2-bit count field chooses how many slow-clock edges to wait for. The field is captured when the sequence begins, so a later write to it does not change a shutdown already in progress. An unmasked interrupt sets the enable bit again, and so does a software write of 1. Either one cancels a pending sequence or wakes a PLL that is already off.

The slow clock passes through a multi-flop synchronizer before its edges are counted. The synchronizer depth, the width of the count field and the minimum delay are all parameters.

Top module: `pll_shutdown_seq`

## Requirements
- R1: After reset, `pll_en` is 1, `rd_pll_en` is 1, `rd_cnt` is 0 and `bus_req` is 0.
- R2: A write with `wr_pll_en`=0 and `wr_cnt`=c at clock edge w starts a sequence. The sequence needs c+1 slow-clock rising edges. When `slow_clk` is first sampled high for the (c+1)-th rise at edge r, and nothing else holds the sequence back, `pll_en` goes low right after edge r+3.
- R3: `pll_en` never goes low earlier than MIN_DLY (default 16) bus-clock cycles after the write edge w. With no other constraint it falls right after edge w+MIN_DLY.
- R4: `pll_en` does not go low while `bus_cycle_done` is 0. If that input is the last condition to be met and first reads 1 at edge d, `pll_en` falls right after d.
- R5: `bus_req` is 1 from the edge after the write until the edge at which `pll_en` falls, and it is 0 while `pll_en` is 0. Shutdown needs `bus_gnt`=1 at the deciding edge.
- R6: A write with `wr_pll_en`=1 during a pending sequence aborts it. `bus_req` drops, `pll_en` stays 1, and the slow-edge count starts from zero in the next sequence.
- R7: An `irq` pulse sampled at edge k sets `rd_pll_en` to 1 after k. It cancels a pending sequence. If the PLL is off, `pll_en` is still 0 after k and is 1 after edge k+1.
- R8: The count field is captured when the sequence starts. A later write of a different `wr_cnt` shows on `rd_cnt` but does not change the edge count needed by the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_pll_en | input | 1 | Value written to the enable bit |
| wr_cnt | input | CNT_W | Value written to the count field |
| rd_pll_en | output | 1 | Current value of the enable bit |
| rd_cnt | output | CNT_W | Current value of the count field |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cycle_done | input | 1 | High when no bus cycle is in progress |
| slow_clk | input | 1 | Asynchronous 32 kHz reference |
| irq | input | 1 | Unmasked interrupt event |
| pll_en | output | 1 | Enable to the analog PLL |

## Verification
The hardest case to reach is one where a single condition decides the shutdown cycle: the slow-edge count, the minimum delay, or the bus-cycle-done input. Each must be the late one while the other two are already met, and the slow edges must land at exact bus-clock offsets despite the synchronizer. The bench generates the slow clock itself, lined up with the bus clock. It sweeps every count setting against early and late edge placements, short and long edge spacing, and early and late cycle completion. It computes the expected falling edge as the maximum of the three terms. Dedicated runs then cover three more cases: a withheld grant, a count field rewritten in mid-sequence, and cancellation by software and by interrupt.

// File: rtl/pllsd_pkg.sv
`timescale 1ns/1ps
package pllsd_pkg;

   // Sequencer phases: PLL running, shutdown pending, PLL stopped
   typedef enum logic [1:0] {
      SEQ_RUN  = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_OFF  = 2'd2
   } seq_state_t;

endpackage

// File: rtl/pllsd_sync_edge.sv
`timescale 1ns/1ps
// Synchronizes an asynchronous level and emits a one-cycle pulse on its rising edge.
module pllsd_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("pllsd_sync_edge: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_pair
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= async_in;
               chain[1] <= chain[0];
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain <= {chain[STAGES-2:0], async_in};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= 1'b0;
      else        last <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last;

endmodule

// File: rtl/pllsd_edge_count.sv
`timescale 1ns/1ps
// Counts synchronized slow-clock rises while enabled; reports when the target is passed.
module pllsd_edge_count #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             rise,
   input  logic [CNT_W-1:0] target,
   output logic             reached
);

   localparam int VW = CNT_W + 1;
   localparam int MAXV = 1 << CNT_W;

   logic [VW-1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen <= '0;
      end else if (clear) begin
         seen <= '0;
      end else if (rise && (seen != VW'(MAXV))) begin
         seen <= seen + VW'(1);
      end
   end

   assign reached = (seen > {1'b0, target});

endmodule

// File: rtl/pllsd_min_delay.sv
`timescale 1ns/1ps
// Counts fast-clock cycles spent in the pending phase; done once the minimum is covered.
module pllsd_min_delay #(
   parameter int MIN_DLY = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic done
);

   // Two cycles are absorbed by the enable register and the phase register.
   localparam int LIM = MIN_DLY - 2;
   localparam int W   = $clog2(LIM + 1);

   logic [W-1:0] ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks <= '0;
      end else if (clear) begin
         ticks <= '0;
      end else if (ticks != W'(LIM)) begin
         ticks <= ticks + W'(1);
      end
   end

   assign done = (ticks == W'(LIM));

endmodule

// File: rtl/pll_shutdown_seq.sv
`timescale 1ns/1ps
module pll_shutdown_seq
   import pllsd_pkg::*;
#(
   parameter int CNT_W       = 2,
   parameter int MIN_DLY     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_pll_en,
   input  logic [CNT_W-1:0] wr_cnt,
   output logic             rd_pll_en,
   output logic [CNT_W-1:0] rd_cnt,
   output logic             bus_req,
   input  logic             bus_gnt,
   input  logic             bus_cycle_done,
   input  logic             slow_clk,
   input  logic             irq,
   output logic             pll_en
);

   generate
      if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
         $error("pll_shutdown_seq: CNT_W out of range");
      end
      if (MIN_DLY < 3) begin : g_bad_dly
         $error("pll_shutdown_seq: MIN_DLY must be at least 3");
      end
   endgenerate

   logic             en_bit;
   logic [CNT_W-1:0] cnt_field;
   logic [CNT_W-1:0] cnt_held;
   seq_state_t       state, state_nx;
   logic             slow_rise;
   logic             edge_ok;
   logic             dly_ok;
   logic             not_pending;
   logic             may_stop;

   // Software-visible enable bit: interrupt wins over a write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_bit <= 1'b1;
      else if (irq)    en_bit <= 1'b1;
      else if (wr_en)  en_bit <= wr_pll_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_field <= '0;
      else if (wr_en) cnt_field <= wr_cnt;
   end

   // Count setting captured at sequence start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  cnt_held <= '0;
      else if (state == SEQ_RUN && !en_bit)        cnt_held <= cnt_field;
   end

   assign not_pending = (state != SEQ_WAIT);

   pllsd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (slow_clk),
      .rise     (slow_rise)
   );

   pllsd_edge_count #(.CNT_W(CNT_W)) u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (not_pending),
      .rise    (slow_rise),
      .target  (cnt_held),
      .reached (edge_ok)
   );

   pllsd_min_delay #(.MIN_DLY(MIN_DLY)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (not_pending),
      .done  (dly_ok)
   );

   assign may_stop = edge_ok & dly_ok & bus_gnt & bus_cycle_done;

   always_comb begin
      state_nx = state;
      unique case (state)
         SEQ_RUN:  if (!en_bit) state_nx = SEQ_WAIT;
         SEQ_WAIT: begin
            if (en_bit)        state_nx = SEQ_RUN;
            else if (may_stop) state_nx = SEQ_OFF;
         end
         SEQ_OFF:  if (en_bit) state_nx = SEQ_RUN;
         default:  state_nx = SEQ_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEQ_RUN;
      else        state <= state_nx;
   end

   assign pll_en    = (state != SEQ_OFF);
   assign bus_req   = (state == SEQ_WAIT);
   assign rd_pll_en = en_bit;
   assign rd_cnt    = cnt_field;

endmodule

// File: rtl/pllsd_checker.sv
`timescale 1ns/1ps
module pllsd_checker #(
   parameter int MIN_DLY = 16
) (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic wr_pll_en,
   input logic rd_pll_en,
   input logic bus_req,
   input logic bus_gnt,
   input logic bus_cycle_done,
   input logic irq,
   input logic edge_ok,
   input logic pll_en
);

   localparam int CW = $clog2(MIN_DLY + 1);

   // Cycles since the enable bit was last seen set, saturating
   logic [CW-1:0] since_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          since_clr <= '0;
      else if (rd_pll_en)                  since_clr <= '0;
      else if (since_clr != CW'(MIN_DLY))  since_clr <= since_clr + CW'(1);
   end

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pll_en && !bus_req));

   assert_edges_before_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_en) |-> $past(edge_ok));

   assert_min_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_en) |-> (since_clr == CW'(MIN_DLY)));

   assert_cycle_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_en) |-> $past(bus_cycle_done));

   assert_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_en) |-> ($past(bus_req) && $past(bus_gnt)));

   assert_req_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_en |-> !bus_req);

   assert_sw_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_pll_en) |=> rd_pll_en);

   assert_irq_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> rd_pll_en);

endmodule

bind pll_shutdown_seq pllsd_checker #(.MIN_DLY(MIN_DLY)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .wr_pll_en      (wr_pll_en),
   .rd_pll_en      (rd_pll_en),
   .bus_req        (bus_req),
   .bus_gnt        (bus_gnt),
   .bus_cycle_done (bus_cycle_done),
   .irq            (irq),
   .edge_ok        (edge_ok),
   .pll_en         (pll_en)
);

// File: tb/pll_shutdown_seq_bench.sv
`timescale 1ns/1ps
module pll_shutdown_seq_bench;

   localparam int CNT_W   = 2;
   localparam int MIN_DLY = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic             wr_pll_en = 1'b1;
   logic [CNT_W-1:0] wr_cnt = '0;
   logic             rd_pll_en;
   logic [CNT_W-1:0] rd_cnt;
   logic             bus_req;
   logic             bus_gnt;
   logic             bus_cycle_done = 1'b0;
   logic             slow_clk = 1'b0;
   logic             irq = 1'b0;
   logic             pll_en;
   logic             gnt_allow = 1'b1;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   always #2.5 clk = ~clk;

   assign bus_gnt = bus_req & gnt_allow;

   pll_shutdown_seq #(.CNT_W(CNT_W), .MIN_DLY(MIN_DLY), .SYNC_STAGES(2)) u_pll_shutdown_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (wr_en),
      .wr_pll_en      (wr_pll_en),
      .wr_cnt         (wr_cnt),
      .rd_pll_en      (rd_pll_en),
      .rd_cnt         (rd_cnt),
      .bus_req        (bus_req),
      .bus_gnt        (bus_gnt),
      .bus_cycle_done (bus_cycle_done),
      .slow_clk       (slow_clk),
      .irq            (irq),
      .pll_en         (pll_en)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit slow_at(input int j, input int off, input int per, input int nr);
      if (j < off) return 1'b0;
      if ((j - off) / per >= nr) return 1'b0;
      return ((j - off) % per) < ((per + 1) / 2);
   endfunction

   // Re-enable the PLL and let the synchronizer settle with slow clock low
   task automatic restore();
      @(negedge clk);
      wr_en = 1'b1; wr_pll_en = 1'b1; slow_clk = 1'b0; irq = 1'b0;
      bus_cycle_done = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   // Start a sequence at edge index 0 and run len edges.
   // mw_kind: 0 none, 1 register write at edge mw_i, 2 irq at edge mw_i.
   task automatic run_seq(input int c, input int off, input int per, input int nr,
                          input int d, input int len,
                          input int mw_kind, input int mw_i, input bit mw_en,
                          input int mw_cnt,
                          output int off_at, output int req_bad);
      off_at  = -1;
      req_bad = 0;
      @(negedge clk);
      wr_en = 1'b1; wr_pll_en = 1'b0; wr_cnt = CNT_W'(c);
      slow_clk = 1'b0; bus_cycle_done = (d <= 0);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (off_at < 0 && !pll_en) off_at = i;
         if (i >= 1 && off_at < 0 && !bus_req) req_bad++;
         if (off_at >= 0 && bus_req) req_bad++;
         wr_en = 1'b0; irq = 1'b0;
         if (mw_kind == 1 && i + 1 == mw_i) begin
            wr_en = 1'b1; wr_pll_en = mw_en; wr_cnt = CNT_W'(mw_cnt);
         end
         if (mw_kind == 2 && i + 1 == mw_i) irq = 1'b1;
         slow_clk = slow_at(i + 1, off, per, nr);
         bus_cycle_done = (i + 1 >= d);
      end
      @(negedge clk);
      wr_en = 1'b0; irq = 1'b0;
   endtask

   initial begin
      #(5ns * 150000);
      if (!ended) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int oa, rb, e, t1, t2;
      string tag;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(pll_en == 1'b1, "R1 pll_en", pll_en, 1);
      check(rd_pll_en == 1'b1, "R1 rd_pll_en", rd_pll_en, 1);
      check(rd_cnt == '0, "R1 rd_cnt", rd_cnt, 0);
      check(bus_req == 1'b0, "R1 bus_req", bus_req, 0);

      // Sweep: count setting x first-edge offset x spacing x cycle-done time
      for (int c = 0; c < 4; c++) begin
         for (int oi = 0; oi < 2; oi++) begin
            for (int pi = 0; pi < 2; pi++) begin
               for (int di = 0; di < 2; di++) begin
                  int off, per, d;
                  off = (oi == 0) ? 1 : 20;
                  per = (pi == 0) ? 3 : 10;
                  d   = (di == 0) ? 0 : 60;
                  restore();
                  run_seq(c, off, per, 1000, d, 100, 0, 0, 1'b0, 0, oa, rb);
                  t1 = off + c * per + 3;
                  e  = t1;
                  tag = "R2 edge-count timing";
                  if (MIN_DLY > e) begin e = MIN_DLY; tag = "R3 minimum delay"; end
                  if (d > e)       begin e = d;       tag = "R4 cycle done";    end
                  check(oa == e, tag, oa, e);
                  check(rb == 0, "R5 request window", rb, 0);
                  check(rd_cnt == CNT_W'(c), "R8 rd_cnt readback", rd_cnt, c);
               end
            end
         end
      end

      // R5: grant withheld blocks shutdown; grant releases it on the next edge
      restore();
      gnt_allow = 1'b0;
      run_seq(0, 1, 4, 1, 0, 40, 0, 0, 1'b0, 0, oa, rb);
      check(oa == -1, "R5 no grant no shutdown", oa, -1);
      check(bus_req == 1'b1, "R5 request held", bus_req, 1);
      gnt_allow = 1'b1;
      @(negedge clk);
      check(pll_en == 1'b0, "R5 shutdown after grant", pll_en, 0);
      check(bus_req == 1'b0, "R5 request released", bus_req, 0);

      // R7: irq while off
      @(negedge clk);
      irq = 1'b1;
      @(negedge clk);
      irq = 1'b0;
      check(pll_en == 1'b0, "R7 pll_en one edge after irq", pll_en, 0);
      check(rd_pll_en == 1'b1, "R7 enable bit set by irq", rd_pll_en, 1);
      @(negedge clk);
      check(pll_en == 1'b1, "R7 pll_en two edges after irq", pll_en, 1);

      // R6: software abort after one counted edge, then a fresh sequence needs two edges
      restore();
      run_seq(1, 1, 40, 1, 0, 60, 1, 8, 1'b1, 1, oa, rb);
      check(oa == -1, "R6 abort keeps pll on", oa, -1);
      check(bus_req == 1'b0, "R6 abort drops request", bus_req, 0);
      check(pll_en == 1'b1, "R6 pll_en after abort", pll_en, 1);
      restore();
      run_seq(1, 1, 40, 2, 0, 80, 0, 0, 1'b0, 0, oa, rb);
      t2 = 1 + 40 + 3;
      check(oa == t2, "R6 edge count restarted", oa, t2);

      // R7: irq during pending sequence cancels it
      restore();
      run_seq(0, 1, 40, 1, 0, 40, 2, 5, 1'b0, 0, oa, rb);
      check(oa == -1, "R7 irq cancels sequence", oa, -1);
      check(bus_req == 1'b0, "R7 request released", bus_req, 0);
      check(rd_pll_en == 1'b1, "R7 enable bit", rd_pll_en, 1);

      // R8: count rewritten mid-sequence keeps the captured setting
      restore();
      run_seq(3, 1, 5, 1000, 0, 60, 1, 3, 1'b0, 0, oa, rb);
      t2 = 1 + 3 * 5 + 3;
      check(oa == t2, "R8 captured count", oa, t2);
      check(rd_cnt == '0, "R8 new field visible", rd_cnt, 0);

      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule